// File: doc/BRIEF.md
# Ethernet Port Status LED Controller

This block turns the status of one 10/100 Ethernet port into the drive levels of three indicator LED pins. The inputs are link-good, line speed, duplex, transmit and receive activity, and collision. The outputs are a link pin, a speed pin and a third pin whose meaning depends on the selected display mode. The link pin can be steady or can blink while frames move, and the third pin shows activity, collision or duplex.

The LED pins double as strap pins, so each board pulls every pin up or down. The block captures those strap levels while reset is asserted and uses each one as the resting (dark) level of its own pin. A pin pulled up therefore drives low to light its LED. The display mode arrives as a two-bit code from strap or register logic outside the block. One more register bit chooses duplex instead of collision in mode 3.

Blinking comes from a parameterised phase length of `PHASE_CYCLES` clocks. The default gives 50 ms per phase at 25 MHz. Any cycle with transmit or receive activity opens an activity window that lasts two phases after the last active cycle. The first blink phase is a dark phase, so even a single-cycle pulse produces one full visible blink.

Top module: `phy_led_ctrl`

## Requirements
- R1: While `rst` is high, `strap_lvl` is captured as the per-pin polarity and every pin is driven to its captured level (dark). After reset, changes on `strap_lvl` have no effect.
- R2: The speed pin is lit exactly when `speed_100` is 1, in every mode and whatever the link state.
- R3: In mode 1 (code 2'b01), the link pin is lit exactly when `link_up` is 1 and never blinks.
- R4: In mode 2 (2'b10) and mode 3 (2'b11), the link pin is lit when `link_up` is 1, except during the dark phases of the blink. Blink phases alternate every `PHASE_CYCLES` clocks, starting with a dark phase one cycle after activity arrives while no window is open.
- R5: The activity window closes 2*`PHASE_CYCLES` cycles after the last cycle in which `tx_act` or `rx_act` was 1. A single active cycle after a quiet period darkens the link pin for exactly `PHASE_CYCLES` cycles.
- R6: In mode 1, the third pin is lit when `link_up` is 1 and there is activity in the current cycle or the activity window is open. A single pulse gives 2*`PHASE_CYCLES`+1 lit cycles.
- R7: In mode 2, the third pin is lit exactly when `link_up` and `coll` are both 1.
- R8: In mode 3, the third pin shows `full_dup` when `dup_sel` is 1 and `coll` when `dup_sel` is 0, gated by `link_up` in both cases.
- R9: While `link_up` is 0, the link pin and the third pin are dark in every mode.
- R10: Mode code 2'b00 behaves exactly like mode 1.
- R11: Each pin level equals its lit state XOR its captured strap bit: bit 0 is the link pin, bit 1 the speed pin, bit 2 the third pin.
- R12: Every pin is registered. It shows the inputs sampled at the previous rising clock edge, combined with the blink state as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; strap levels are captured while high |
| strap_lvl | input | 3 | Strap level of each pin (bit 0 link, 1 speed, 2 third) |
| led_mode | input | 2 | Display mode code: 00/01 mode 1, 10 mode 2, 11 mode 3 |
| dup_sel | input | 1 | In mode 3, 1 selects duplex and 0 selects collision for the third pin |
| link_up | input | 1 | Link is good |
| speed_100 | input | 1 | 1 for 100 Mb/s, 0 for 10 Mb/s |
| full_dup | input | 1 | Full duplex in use |
| tx_act | input | 1 | Transmit activity this cycle |
| rx_act | input | 1 | Receive activity this cycle |
| coll | input | 1 | Collision in progress |
| led_link_pin | output | 1 | Link or link/activity pin level |
| led_spd_pin | output | 1 | Speed pin level |
| led_act_pin | output | 1 | Third pin level: activity, collision or duplex |

## Verification
A wrong polarity register shows up on every pin in the first cycle after reset, as a lit LED where a dark one is expected. A faulty quiet counter or phase counter stays hidden until activity happens. Once it does, the link pin's dark phase starts late, lasts the wrong number of cycles, or the window closes early or late; in mode 1 the third pin shows the same error within 2*`PHASE_CYCLES`+1 cycles of a pulse. A wrong mode decode shows on the third pin in the first cycle that `coll`, `full_dup` or activity disagree with each other.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;

    localparam int LED_COUNT = 3;
    localparam int PIN_LINK  = 0;
    localparam int PIN_SPEED = 1;
    localparam int PIN_THIRD = 2;

    typedef enum logic [1:0] {
        MODE_DEF   = 2'b00,
        MODE_ONE   = 2'b01,
        MODE_TWO   = 2'b10,
        MODE_THREE = 2'b11
    } led_mode_e;

    typedef enum logic [1:0] {
        SRC_ACTIVITY,
        SRC_COLLISION,
        SRC_DUPLEX
    } third_src_e;

    // bit order matches the strap vector: link, speed, third
    typedef struct packed {
        logic third;
        logic speed;
        logic link;
    } led_lit_t;

    function automatic third_src_e pick_third(input led_mode_e mode, input logic dup_sel);
        third_src_e src;
        case (mode)
            MODE_TWO:   src = SRC_COLLISION;
            MODE_THREE: src = dup_sel ? SRC_DUPLEX : SRC_COLLISION;
            default:    src = SRC_ACTIVITY;
        endcase
        return src;
    endfunction

    function automatic logic link_blinks(input led_mode_e mode);
        return (mode == MODE_TWO) || (mode == MODE_THREE);
    endfunction

endpackage

// File: rtl/led_act_window.sv
module led_act_window #(
    parameter int WINDOW_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic act_any,
    output logic in_window
);
    localparam int QW = $clog2(WINDOW_CYCLES + 1);
    localparam logic [QW-1:0] QUIET_MAX = QW'(WINDOW_CYCLES);

    logic [QW-1:0] quiet_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_q <= QUIET_MAX;
        end else if (act_any) begin
            quiet_q <= '0;
        end else if (quiet_q != QUIET_MAX) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    assign in_window = (quiet_q != QUIET_MAX);

endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
    parameter int PHASE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic act_any,
    input  logic in_window,
    output logic blink_dark
);
    localparam int PW = $clog2(PHASE_CYCLES + 1);
    localparam logic [PW-1:0] PH_LAST = PW'(PHASE_CYCLES - 1);

    logic [PW-1:0] ph_q;
    logic          dark_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            dark_q <= 1'b0;
        end else if (!in_window) begin
            // a fresh burst starts in the dark phase
            ph_q   <= '0;
            dark_q <= act_any;
        end else if (ph_q == PH_LAST) begin
            ph_q   <= '0;
            dark_q <= ~dark_q;
        end else begin
            ph_q   <= ph_q + 1'b1;
        end
    end

    assign blink_dark = in_window && dark_q;

endmodule

// File: rtl/led_pin_drive.sv
module led_pin_drive #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] strap_lvl,
    input  logic [N-1:0] lit,
    output logic [N-1:0] pins,
    output logic [N-1:0] pol_lvl
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic pol_q;
        logic pin_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                pol_q <= strap_lvl[i];
                pin_q <= strap_lvl[i];
            end else begin
                pin_q <= lit[i] ^ pol_q;
            end
        end

        assign pins[i]    = pin_q;
        assign pol_lvl[i] = pol_q;
    end

endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl
    import phy_led_pkg::*;
#(
    parameter int PHASE_CYCLES = 1250000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] strap_lvl,
    input  logic [1:0] led_mode,
    input  logic       dup_sel,
    input  logic       link_up,
    input  logic       speed_100,
    input  logic       full_dup,
    input  logic       tx_act,
    input  logic       rx_act,
    input  logic       coll,
    output logic       led_link_pin,
    output logic       led_spd_pin,
    output logic       led_act_pin
);
    localparam int WINDOW_CYCLES = 2 * PHASE_CYCLES;

    logic                 act_any;
    logic                 in_window;
    logic                 blink_dark;
    led_mode_e            mode;
    third_src_e           third_src;
    led_lit_t             lit;
    logic [LED_COUNT-1:0] pins;
    logic [LED_COUNT-1:0] pol_lvl;

    assign act_any   = tx_act | rx_act;
    assign mode      = led_mode_e'(led_mode);
    assign third_src = pick_third(mode, dup_sel);

    led_act_window #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_window (
        .clk       (clk),
        .rst       (rst),
        .act_any   (act_any),
        .in_window (in_window)
    );

    led_blink_gen #(.PHASE_CYCLES(PHASE_CYCLES)) u_blink (
        .clk        (clk),
        .rst        (rst),
        .act_any    (act_any),
        .in_window  (in_window),
        .blink_dark (blink_dark)
    );

    always_comb begin
        lit.speed = speed_100;
        lit.link  = link_up && !(link_blinks(mode) && blink_dark);
        case (third_src)
            SRC_COLLISION: lit.third = link_up && coll;
            SRC_DUPLEX:    lit.third = link_up && full_dup;
            default:       lit.third = link_up && (act_any || in_window);
        endcase
    end

    led_pin_drive #(.N(LED_COUNT)) u_drive (
        .clk       (clk),
        .rst       (rst),
        .strap_lvl (strap_lvl),
        .lit       (lit),
        .pins      (pins),
        .pol_lvl   (pol_lvl)
    );

    assign led_link_pin = pins[PIN_LINK];
    assign led_spd_pin  = pins[PIN_SPEED];
    assign led_act_pin  = pins[PIN_THIRD];

endmodule

// File: rtl/phy_led_ctrl_chk.sv
module phy_led_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] led_mode,
    input logic       link_up,
    input logic       speed_100,
    input logic       coll,
    input logic       act_any,
    input logic       in_window,
    input logic [2:0] pol_lvl,
    input logic       led_link_pin,
    input logic       led_spd_pin,
    input logic       led_act_pin
);
    // R1
    pol_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(pol_lvl));

    // R2
    speed_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (led_spd_pin == ($past(speed_100) ^ pol_lvl[1])));

    // R3
    mode1_link_chk: assert property (@(posedge clk) disable iff (rst)
        (led_mode == 2'b01) |=> (led_link_pin == ($past(link_up) ^ pol_lvl[0])));

    // R5
    window_open_chk: assert property (@(posedge clk) disable iff (rst)
        act_any |=> in_window);

    // R7
    mode2_coll_chk: assert property (@(posedge clk) disable iff (rst)
        (led_mode == 2'b10) |=> (led_act_pin == ($past(link_up && coll) ^ pol_lvl[2])));

    // R9
    link_down_dark_chk: assert property (@(posedge clk) disable iff (rst)
        !link_up |=> ((led_link_pin == pol_lvl[0]) && (led_act_pin == pol_lvl[2])));

endmodule

bind phy_led_ctrl phy_led_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .led_mode     (led_mode),
    .link_up      (link_up),
    .speed_100    (speed_100),
    .coll         (coll),
    .act_any      (act_any),
    .in_window    (in_window),
    .pol_lvl      (pol_lvl),
    .led_link_pin (led_link_pin),
    .led_spd_pin  (led_spd_pin),
    .led_act_pin  (led_act_pin)
);

// File: tb/phy_led_ctrl_bench.sv
module phy_led_ctrl_bench;
    localparam int PH  = 4;
    localparam int WIN = 2 * PH;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic [2:0] strap_lvl = 3'b000;
    logic [1:0] led_mode = 2'b01;
    logic       dup_sel = 1'b0, link_up = 1'b0, speed_100 = 1'b0, full_dup = 1'b0;
    logic       tx_act = 1'b0, rx_act = 1'b0, coll = 1'b0;
    logic       led_link_pin, led_spd_pin, led_act_pin;

    phy_led_ctrl #(.PHASE_CYCLES(PH)) u_phy_led_ctrl (
        .clk(clk), .rst(rst), .strap_lvl(strap_lvl), .led_mode(led_mode),
        .dup_sel(dup_sel), .link_up(link_up), .speed_100(speed_100),
        .full_dup(full_dup), .tx_act(tx_act), .rx_act(rx_act), .coll(coll),
        .led_link_pin(led_link_pin), .led_spd_pin(led_spd_pin),
        .led_act_pin(led_act_pin)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    int         m_quiet = WIN, m_ph = 0;
    logic       m_dark = 1'b0;
    logic [2:0] m_pol = 3'b000;
    logic [2:0] exp_pins;
    string      tag_link, tag_thr;
    bit         was_rst;

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // one clock: model evaluates at the edge, pins checked at the next falling edge
    task automatic tick();
        bit   m1, act, win;
        logic l_link, l_spd, l_thr;
        @(posedge clk);
        m1  = (led_mode == 2'b00) || (led_mode == 2'b01);
        act = tx_act || rx_act;
        win = (m_quiet != WIN);
        l_link = link_up && (m1 || !(win && m_dark));
        l_spd  = speed_100;
        if (m1)                    l_thr = link_up && (act || win);
        else if (led_mode == 2'b10) l_thr = link_up && coll;
        else                       l_thr = link_up && (dup_sel ? full_dup : coll);
        if (!link_up) begin tag_link = "R9"; tag_thr = "R9"; end
        else begin
            tag_link = m1 ? ((led_mode == 2'b00) ? "R10" : "R3") : "R4";
            tag_thr  = (led_mode == 2'b00) ? "R10" : (led_mode == 2'b01) ? "R6" :
                       (led_mode == 2'b10) ? "R7" : "R8";
        end
        was_rst = rst;
        if (rst) begin
            m_pol = strap_lvl; m_quiet = WIN; m_ph = 0; m_dark = 1'b0;
            exp_pins = strap_lvl;
        end else begin
            exp_pins = {l_thr, l_spd, l_link} ^ m_pol;
            if (act) m_quiet = 0;
            else if (m_quiet != WIN) m_quiet++;
            if (!win) begin m_ph = 0; m_dark = act; end
            else if (m_ph == PH - 1) begin m_ph = 0; m_dark = ~m_dark; end
            else m_ph++;
        end
        @(negedge clk);
        if (was_rst) begin
            chk("R1 reset link", led_link_pin, exp_pins[0]);
            chk("R1 reset speed", led_spd_pin, exp_pins[1]);
            chk("R1 reset third", led_act_pin, exp_pins[2]);
        end else begin
            chk({tag_link, "/R11/R12 link"}, led_link_pin, exp_pins[0]);
            chk("R2/R11 speed", led_spd_pin, exp_pins[1]);
            chk({tag_thr, "/R11/R12 third"}, led_act_pin, exp_pins[2]);
        end
    endtask

    task automatic do_reset(input logic [2:0] s);
        rst = 1'b1; strap_lvl = s;
        repeat (3) tick();
        rst = 1'b0;
        strap_lvl = ~s;   // R1: strap changes after reset must not matter
    endtask

    task automatic quiet_cycles(input int n);
        tx_act = 0; rx_act = 0;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            if (i % 50 == 0) begin
                led_mode = 2'($urandom_range(0, 3));
                dup_sel  = 1'($urandom_range(0, 1));
                link_up  = ($urandom_range(0, 4) != 0);
                speed_100 = 1'($urandom_range(0, 1));
                full_dup  = 1'($urandom_range(0, 1));
            end
            if ((i / 30) % 3 == 2) begin
                tx_act = 0; rx_act = 0;
            end else begin
                tx_act = ($urandom_range(0, 11) == 0);
                rx_act = ($urandom_range(0, 11) == 0);
            end
            coll = ($urandom_range(0, 5) == 0);
            tick();
        end
    endtask

    initial begin
        int dark_n, lit_n;
        void'($urandom(32'h1ed5_0c4a));
        do_reset(3'b101);
        link_up = 1; speed_100 = 1;

        // R5: single pulse in mode 2 gives exactly PH dark link cycles
        led_mode = 2'b10;
        quiet_cycles(WIN + 2);
        tx_act = 1; tick(); tx_act = 0;
        dark_n = 0;
        for (int i = 0; i < 3 * PH; i++) begin
            tick();
            if (led_link_pin == m_pol[0]) dark_n++;
        end
        chk("R5 dark cycles after one pulse", dark_n == PH, 1'b1);
        if (dark_n != PH) $display("  R5 detail: got %0d expected %0d", dark_n, PH);

        // R6: single pulse in mode 1 keeps third pin lit 2*PH+1 cycles
        led_mode = 2'b01;
        quiet_cycles(WIN + 2);
        rx_act = 1;
        lit_n = 0;
        tick();
        if (led_act_pin != m_pol[2]) lit_n++;
        rx_act = 0;
        for (int i = 0; i < 3 * PH; i++) begin
            tick();
            if (led_act_pin != m_pol[2]) lit_n++;
        end
        chk("R6 lit cycles after one pulse", lit_n == 2 * PH + 1, 1'b1);
        if (lit_n != 2 * PH + 1) $display("  R6 detail: got %0d expected %0d", lit_n, 2 * PH + 1);

        // R8: mode 3 duplex vs collision
        led_mode = 2'b11; coll = 1; full_dup = 0;
        dup_sel = 1; tick(); tick();
        dup_sel = 0; tick(); tick();
        // R9: link down in blinking mode with activity
        link_up = 0; tx_act = 1; tick(); tick(); tx_act = 0;

        random_run(3000);
        do_reset(3'b010);
        random_run(3000);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule